// File: doc/BRIEF.md
# Data-Processing Instruction Executor

This block takes one 32-bit data-processing instruction word per cycle, qualified by a valid strobe, and carries it out in that same clock edge. The first operand always comes from a sixteen-entry, 32-bit register file. The second operand is either another register or a constant. The constant is an 8-bit value rotated right by an even amount. One of sixteen ALU operations is applied. The result is written to the destination register, except for the four compare-only operations. The negative, zero, carry and overflow flags are updated when the instruction asks for it. A combinational debug port reads any register, and the four flags are driven straight from their state bits.

An instruction runs only when its condition field holds the "always" code and bits [27:26] are both zero. Any other word, or a cycle with the strobe low, leaves every register and flag as it was. Register-shifted operands, memory accesses, branches and any other condition code are outside this block.

Top module: `dpx_exec`

## Requirements
- R1: After synchronous reset every register reads 0 on the debug port and all four flags are 0.
- R2: A word whose bits [31:28] are not 4'b1110, or whose bits [27:26] are not 2'b00, changes no register and no flag.
- R3: With bit 25 = 0, the second operand is the register named by bits [3:0]. The first operand is the register named by bits [19:16], and the result goes to the register named by bits [15:12]. For example, 0xE0810002 writes r1 + r2 into r0.
- R4: With bit 25 = 1, the second operand is bits [7:0] rotated right by twice bits [11:8]. For example, 0x01 with a rotate field of 8 gives 0x00010000, and 0xFF with a rotate field of 2 gives 0xF000000F.
- R5: Opcodes (bits [24:21]) 0010 (subtract) and 0011 (reverse subtract) give first minus second and second minus first. Opcode 0100 (add) gives the sum.
- R6: Opcode 0101 adds the carry flag in. Opcode 0110 gives first − second + C − 1. Opcode 0111 gives second − first + C − 1.
- R7: Opcodes 0000 AND, 0001 XOR, 1100 OR, 1110 AND-NOT, 1101 move and 1111 move-inverted work bitwise. The move opcodes ignore the first operand.
- R8: With bit 20 = 1, N takes result bit 31 and Z is set for a zero result. For arithmetic, C is the carry out (not-borrow for subtracts) and V is the signed overflow. With bit 20 = 0 and a writing opcode, the flags do not change.
- R9: Logical opcodes that update flags leave C and V unchanged.
- R10: Opcodes 1000 (AND), 1001 (XOR), 1010 (subtract) and 1011 (add) write no register. They always update the flags, whatever the value of bit 20.
- R11: A cycle with the valid strobe low changes no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Data-processing instruction |
| dbg_addr | input | 4 | Register index for the debug read |
| dbg_data | output | 32 | Combinational contents of the selected register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The register write and the flag update both happen at the rising edge that samples a valid word, so each result is due exactly one edge after its word is presented. The bench drives a word at a falling edge and withdraws the strobe at the next falling edge. At that point, just after the executing edge, it reads the flags and steps the combinational debug port over the registers. Most vectors build on state left by earlier ones, such as the carry consumed by the carry-using opcodes, so the table is walked strictly in order.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

    localparam int WORD_W  = 32;
    localparam int REG_N   = 16;
    localparam int RIDX_W  = $clog2(REG_N);
    localparam int IMM8_W  = 8;
    localparam int ROTF_W  = 4;
    localparam logic [3:0] COND_ALWAYS = 4'b1110;

    typedef enum logic [3:0] {
        OP_AND = 4'b0000, OP_EOR = 4'b0001, OP_SUB = 4'b0010, OP_RSB = 4'b0011,
        OP_ADD = 4'b0100, OP_ADC = 4'b0101, OP_SBC = 4'b0110, OP_RSC = 4'b0111,
        OP_TST = 4'b1000, OP_TEQ = 4'b1001, OP_CMP = 4'b1010, OP_CMN = 4'b1011,
        OP_ORR = 4'b1100, OP_MOV = 4'b1101, OP_BIC = 4'b1110, OP_MVN = 4'b1111
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef struct packed {
        logic                exec;
        alu_op_e             op;
        logic                use_imm;
        logic                upd_flags;
        logic                wr_rd;
        logic [RIDX_W-1:0]   rn;
        logic [RIDX_W-1:0]   rd;
        logic [RIDX_W-1:0]   rm;
        logic [WORD_W-1:0]   imm;
    } dec_t;

    // compare-only opcodes share the 10xx prefix
    function automatic logic is_test(input alu_op_e op);
        return op[3:2] == 2'b10;
    endfunction

    function automatic logic is_arith(input alu_op_e op);
        return (op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC,
                           OP_CMP, OP_CMN});
    endfunction

    // 8-bit constant rotated right by twice the 4-bit field
    function automatic logic [WORD_W-1:0] expand_imm(input logic [11:0] f);
        logic [2*WORD_W-1:0] dbl;
        logic [WORD_W-1:0]   base;
        int unsigned         amt;
        base = {{(WORD_W-IMM8_W){1'b0}}, f[IMM8_W-1:0]};
        amt  = 2 * int'(f[IMM8_W +: ROTF_W]);
        dbl  = {base, base} >> amt;
        return dbl[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/dpx_decode.sv
module dpx_decode
    import dpx_pkg::*;
(
    input  logic              valid,
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    logic    runs;
    alu_op_e op;

    assign runs = valid && (word[31:28] == COND_ALWAYS) && (word[27:26] == 2'b00);
    assign op   = alu_op_e'(word[24:21]);

    always_comb begin
        dec           = '0;
        dec.exec      = runs;
        dec.op        = op;
        dec.use_imm   = word[25];
        dec.upd_flags = runs && (word[20] || is_test(op));
        dec.wr_rd     = runs && !is_test(op);
        dec.rn        = word[19:16];
        dec.rd        = word[15:12];
        dec.rm        = word[RIDX_W-1:0];
        dec.imm       = expand_imm(word[11:0]);
    end
endmodule

// File: rtl/dpx_regfile.sv
module dpx_regfile
    import dpx_pkg::*;
#(
    parameter int DEPTH = REG_N,
    parameter int WIDTH = WORD_W,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr_a,
    input  logic [AW-1:0]    raddr_b,
    input  logic [AW-1:0]    raddr_d,
    output logic [WIDTH-1:0] rdata_a,
    output logic [WIDTH-1:0] rdata_b,
    output logic [WIDTH-1:0] rdata_d
);
    logic [WIDTH-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (we && (waddr == AW'(g)))
                mem[g] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
    assign rdata_d = mem[raddr_d];
endmodule

// File: rtl/dpx_alu.sv
module dpx_alu
    import dpx_pkg::*;
(
    input  alu_op_e           op,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  nzcv_t             fl_in,
    output logic [WORD_W-1:0] res,
    output nzcv_t             fl_out
);
    logic [WORD_W-1:0] x, y, lres;
    logic              ci;
    logic [WORD_W:0]   sum;

    // every arithmetic opcode maps onto x + y + ci
    always_comb begin
        x  = opa;
        y  = opb;
        ci = 1'b0;
        unique case (op)
            OP_SUB, OP_CMP: begin y = ~opb; ci = 1'b1;     end
            OP_RSB:         begin x = opb; y = ~opa; ci = 1'b1; end
            OP_ADC:         begin ci = fl_in.c;           end
            OP_SBC:         begin y = ~opb; ci = fl_in.c;  end
            OP_RSC:         begin x = opb; y = ~opa; ci = fl_in.c; end
            default:        ;
        endcase
    end

    assign sum = {1'b0, x} + {1'b0, y} + {{WORD_W{1'b0}}, ci};

    always_comb begin
        unique case (op)
            OP_AND, OP_TST: lres = opa & opb;
            OP_EOR, OP_TEQ: lres = opa ^ opb;
            OP_ORR:         lres = opa | opb;
            OP_BIC:         lres = opa & ~opb;
            OP_MOV:         lres = opb;
            default:        lres = ~opb;
        endcase
    end

    always_comb begin
        if (is_arith(op)) begin
            res      = sum[WORD_W-1:0];
            fl_out.c = sum[WORD_W];
            fl_out.v = (x[WORD_W-1] == y[WORD_W-1]) && (sum[WORD_W-1] != x[WORD_W-1]);
        end else begin
            res      = lres;
            fl_out.c = fl_in.c;
            fl_out.v = fl_in.v;
        end
        fl_out.n = res[WORD_W-1];
        fl_out.z = (res == '0);
    end
endmodule

// File: rtl/dpx_exec.sv
module dpx_exec
    import dpx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        instr_valid,
    input  logic [31:0] instr_word,
    input  logic [3:0]  dbg_addr,
    output logic [31:0] dbg_data,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_c,
    output logic        flag_v
);
    dec_t              dec;
    nzcv_t             flags, alu_fl;
    logic [WORD_W-1:0] rs_a, rs_b, op2, alu_res;

    dpx_decode u_dec (
        .valid (instr_valid),
        .word  (instr_word),
        .dec   (dec)
    );

    dpx_regfile #(.DEPTH(REG_N), .WIDTH(WORD_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (dec.wr_rd),
        .waddr   (dec.rd),
        .wdata   (alu_res),
        .raddr_a (dec.rn),
        .raddr_b (dec.rm),
        .raddr_d (dbg_addr),
        .rdata_a (rs_a),
        .rdata_b (rs_b),
        .rdata_d (dbg_data)
    );

    assign op2 = dec.use_imm ? dec.imm : rs_b;

    dpx_alu u_alu (
        .op     (dec.op),
        .opa    (rs_a),
        .opb    (op2),
        .fl_in  (flags),
        .res    (alu_res),
        .fl_out (alu_fl)
    );

    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else if (dec.upd_flags)
            flags <= alu_fl;
    end

    assign flag_n = flags.n;
    assign flag_z = flags.z;
    assign flag_c = flags.c;
    assign flag_v = flags.v;

    // non-always condition or bad class bits: state untouched
    p_noexec_r2: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && (instr_word[31:28] != COND_ALWAYS)) |=> $stable(flags));

    // idle cycles leave the flags alone
    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable(flags));

    // compare-only opcodes must not disturb any register seen on the debug port
    p_testop_r10: assert property (@(posedge clk) disable iff (rst)
        (dec.exec && is_test(dec.op)) |=> ((dbg_addr != $past(dbg_addr)) || $stable(dbg_data)));

    // logical ops keep carry and overflow
    p_logic_cv_r9: assert property (@(posedge clk) disable iff (rst)
        (dec.upd_flags && !is_arith(dec.op)) |=> $stable({flag_c, flag_v}));

    // zero and negative follow the result that was produced
    p_zflag_r8: assert property (@(posedge clk) disable iff (rst)
        dec.upd_flags |=> (flag_z == ($past(alu_res) == '0)));

    p_nflag_r8: assert property (@(posedge clk) disable iff (rst)
        dec.upd_flags |=> (flag_n == $past(alu_res[WORD_W-1])));

    // flag-free writing instructions keep the flags
    p_noset_r8: assert property (@(posedge clk) disable iff (rst)
        (dec.exec && !dec.upd_flags) |=> $stable(flags));
endmodule

// File: tb/tb_dpx_exec.sv
module tb_dpx_exec;

    localparam logic [3:0] AND_ = 4'h0, EOR_ = 4'h1, SUB_ = 4'h2, RSB_ = 4'h3,
                           ADD_ = 4'h4, ADC_ = 4'h5, SBC_ = 4'h6, RSC_ = 4'h7,
                           TST_ = 4'h8, TEQ_ = 4'h9, CMP_ = 4'hA, CMN_ = 4'hB,
                           ORR_ = 4'hC, MOV_ = 4'hD, BIC_ = 4'hE, MVN_ = 4'hF;

    function automatic logic [31:0] enc(input logic [3:0] op, input logic i, input logic s,
                                        input logic [3:0] rn, input logic [3:0] rd,
                                        input logic [11:0] o2);
        return {4'hE, 2'b00, i, op, s, rn, rd, o2};
    endfunction

    typedef struct packed {
        logic [31:0] w;
        logic [3:0]  reg_i;
        logic [31:0] val;
        logic [3:0]  nzcv;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{enc(MOV_,1,0,0,1,12'h005), 4'd1, 32'h5,        4'b0000, 8'd4},  // R4
        '{enc(MOV_,1,0,0,2,12'h007), 4'd2, 32'h7,        4'b0000, 8'd4},
        '{32'hE0810002,              4'd0, 32'hC,        4'b0000, 8'd3},  // R3
        '{32'hE2810001,              4'd0, 32'h6,        4'b0000, 8'd3},
        '{enc(MOV_,1,0,0,3,12'h801), 4'd3, 32'h00010000, 4'b0000, 8'd4},
        '{enc(MOV_,1,0,0,4,12'h2FF), 4'd4, 32'hF000000F, 4'b0000, 8'd4},
        '{enc(SUB_,0,1,1,5,12'h002), 4'd5, 32'hFFFFFFFE, 4'b1000, 8'd5},  // R5
        '{enc(RSB_,0,0,1,6,12'h002), 4'd6, 32'h2,        4'b1000, 8'd5},
        '{enc(ADD_,0,1,4,7,12'h004), 4'd7, 32'hE000001E, 4'b1010, 8'd8},  // R8
        '{enc(ADC_,1,0,1,8,12'h000), 4'd8, 32'h6,        4'b1010, 8'd6},  // R6
        '{enc(SBC_,0,0,2,9,12'h001), 4'd9, 32'h2,        4'b1010, 8'd6},
        '{enc(RSC_,1,1,1,10,12'h00A),4'd10,32'h5,        4'b0010, 8'd6},
        '{enc(CMP_,1,0,1,11,12'h005),4'd11,32'h0,        4'b0110, 8'd10}, // R10
        '{enc(TST_,1,0,4,11,12'h00F),4'd11,32'h0,        4'b0010, 8'd10},
        '{enc(MOV_,1,0,0,12,12'h47F),4'd12,32'h7F000000, 4'b0010, 8'd4},
        '{enc(ADD_,0,1,12,13,12'h00C),4'd13,32'hFE000000,4'b1001, 8'd8},
        '{enc(SBC_,0,0,2,14,12'h001),4'd14,32'h1,        4'b1001, 8'd6},
        '{enc(AND_,1,1,4,5,12'h0F0), 4'd5, 32'h0,        4'b0101, 8'd9},  // R9
        '{enc(EOR_,0,0,1,5,12'h002), 4'd5, 32'h2,        4'b0101, 8'd7},  // R7
        '{enc(ORR_,1,0,1,5,12'h030), 4'd5, 32'h35,       4'b0101, 8'd7},
        '{enc(BIC_,1,0,4,5,12'h00F), 4'd5, 32'hF0000000, 4'b0101, 8'd7},
        '{enc(MOV_,1,0,4,5,12'h009), 4'd5, 32'h9,        4'b0101, 8'd7},
        '{enc(MVN_,1,1,3,5,12'h000), 4'd5, 32'hFFFFFFFF, 4'b1001, 8'd9},
        '{enc(TEQ_,0,0,1,11,12'h001),4'd11,32'h0,        4'b0101, 8'd10},
        '{enc(CMN_,0,0,12,11,12'h00C),4'd11,32'h0,       4'b1001, 8'd10},
        '{enc(SUB_,0,1,3,5,12'h003), 4'd5, 32'h0,        4'b0110, 8'd8}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic [3:0]  dbg_addr = '0;
    logic [31:0] dbg_data;
    logic        flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dpx_exec dut (
        .clk (clk), .rst (rst), .instr_valid (instr_valid), .instr_word (instr_word),
        .dbg_addr (dbg_addr), .dbg_data (dbg_data),
        .flag_n (flag_n), .flag_z (flag_z), .flag_c (flag_c), .flag_v (flag_v)
    );

    always @(posedge clk) cycles <= cycles + 1;

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_reg(input string tag, input logic [3:0] r, input logic [31:0] exp);
        dbg_addr = r;
        #1;
        check_val($sformatf("%s r%0d", tag, r), dbg_data, exp);
    endtask

    task automatic check_flags(input string tag, input logic [3:0] exp);
        check_val($sformatf("%s nzcv", tag), {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, exp});
    endtask

    // drive at a falling edge, execute on the rising edge, sample at the next falling edge
    task automatic issue(input logic [31:0] w, input logic v);
        @(negedge clk);
        instr_word  = w;
        instr_valid = v;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        for (int r = 0; r < 16; r++) check_reg("R1", 4'(r), 32'h0);
        check_flags("R1", 4'b0000);

        for (int k = 0; k < NV; k++) begin
            issue(VECS[k].w, 1'b1);
            check_reg($sformatf("R%0d vec%0d", VECS[k].req, k), VECS[k].reg_i, VECS[k].val);
            check_flags($sformatf("R%0d vec%0d", VECS[k].req, k), VECS[k].nzcv);
        end
        // R10: compare-only ops left r11 untouched throughout
        check_reg("R10", 4'd11, 32'h0);
        // R7: move opcodes ignored nonzero first operand field; r1 kept
        check_reg("R7", 4'd1, 32'h5);

        // R2: wrong condition code
        issue({4'h0, 2'b00, 1'b1, MOV_, 1'b1, 4'd0, 4'd1, 12'h0AA}, 1'b1);
        check_reg("R2 cond", 4'd1, 32'h5);
        check_flags("R2 cond", 4'b0110);
        // R2: class bits not 00
        issue({4'hE, 2'b01, 1'b1, MOV_, 1'b1, 4'd0, 4'd2, 12'h000}, 1'b1);
        check_reg("R2 class", 4'd2, 32'h7);
        check_flags("R2 class", 4'b0110);
        // R11: strobe low
        issue(enc(MVN_,1,1,0,3,12'h000), 1'b0);
        check_reg("R11", 4'd3, 32'h00010000);
        check_flags("R11", 4'b0110);
        // R8: writing op without set bit keeps flags
        issue(enc(MVN_,1,0,0,15,12'h000), 1'b1);
        check_reg("R8 noset", 4'd15, 32'hFFFFFFFF);
        check_flags("R8 noset", 4'b0110);

        // R1: reset again clears state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check_reg("R1 rerst", 4'd15, 32'h0);
        check_flags("R1 rerst", 4'b0000);
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
        end
        #2;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule